// File: doc/BRIEF.md
# Receive Jabber Timeout Monitor

This block supervises the receive side of a 100 Mb/s link, one symbol per clock. When the upstream logic signals that a reception has begun, the monitor raises carrier sense and starts two counters. One measures how long the reception has lasted. The other counts consecutive idle symbols. A reception closes normally once a configurable run of back-to-back idle symbols has been seen. At that point carrier sense falls and a one-cycle end pulse is issued.

If the reception is still carrying data when the duration limit is reached, the monitor declares jabber. It then holds carrier sense and a jabber flag until the line goes quiet for the same idle run. A packet whose data stops shortly before the limit can still be finishing its idle run when the limit is reached. In that case the jabber decision is deferred. If the idle run completes, the reception ends cleanly, with no jabber and no break in carrier sense. Only a data symbol arriving after the limit turns the reception into jabber.

Both the duration limit and the idle run length are parameters counted in symbol clocks. The default limit corresponds to roughly 722 us at a 25 MHz nibble clock (18050 symbols). This is far above the roughly 3025 symbols a maximum-length 1514-byte frame occupies.

Top module: `rx_jabber_monitor`

## Requirements
- R1: While rst_n is low, and in the cycle after it is released, crs, jabber and rx_end are all 0; asserting rst_n in mid-reception clears all three at once.
- R2: With no reception in progress, sampling rx_active = 1 at a clock edge starts a reception, and crs reads 1 after that edge; while rx_active stays 0, crs stays 0 whatever sym_idle does.
- R3: Symbols are counted from the edge after the starting edge (symbol 1). The reception ends at the edge that samples the IDLE_RUN-th consecutive sym_idle = 1. After that edge crs = 0, jabber = 0 and rx_end = 1, and rx_end is 1 for exactly one cycle.
- R4: A symbol with sym_idle = 0 restarts the idle run, so a burst of fewer than IDLE_RUN idle symbols inside a reception does not end it.
- R5: A reception whose idle run completes at or before symbol TIMEOUT never raises jabber.
- R6: When the idle run completes exactly at symbol TIMEOUT, the normal end wins: rx_end pulses and jabber stays 0.
- R7: If symbol TIMEOUT is idle but the run is not yet complete, the verdict waits. Completing the run ends the reception with no jabber and crs held continuously high. A later non-idle symbol raises jabber after the edge that samples it.
- R8: If symbol TIMEOUT is non-idle, jabber reads 1 after that edge and crs remains 1.
- R9: Jabber stays 1 until the idle run completes; at that edge jabber and crs both fall and rx_end pulses.
- R10: rx_active has no effect while a reception is in progress: holding it high neither restarts the duration count nor extends the reception.
- R11: The duration count restarts for every reception, so back-to-back receptions, each shorter than TIMEOUT, never accumulate toward jabber.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_active | input | 1 | Request to open a reception, sampled only when none is in progress |
| sym_idle | input | 1 | Current symbol is an idle symbol |
| crs | output | 1 | Carrier sense, high for the whole reception including any jabber period |
| jabber | output | 1 | Reception has overrun the duration limit |
| rx_end | output | 1 | One-cycle pulse when a reception closes |

## Verification
The bench builds the monitor with TIMEOUT = 40 and IDLE_RUN = 6. This makes every reception in the vector table only a few dozen cycles long. It lets data lengths of 34, 35, 39, 40 and 45 symbols straddle the limit precisely: the idle run completing exactly on the limit, the run still in progress when the limit is reached, and data continuing past it. Back-to-back receptions of 38 symbols show that the duration count restarts. An idle burst overlapping the limit shows the deferred verdict turning into jabber.

// File: rtl/rx_jabber_pkg.sv
package rx_jabber_pkg;

  typedef enum logic [1:0] {
    MON_IDLE  = 2'd0,
    MON_RECV  = 2'd1,
    MON_GRACE = 2'd2,
    MON_JAB   = 2'd3
  } mon_state_e;

  // True when the symbol now sampled closes the idle run.
  function automatic logic idle_run_closes(input int unsigned run_so_far,
                                           input logic this_idle,
                                           input int unsigned run_len);
    return this_idle && (run_so_far + 1 == run_len);
  endfunction

  // True when the duration count sits on the last allowed symbol.
  function automatic logic duration_at_limit(input int unsigned elapsed,
                                             input int unsigned limit);
    return (elapsed + 1 == limit);
  endfunction

endpackage

// File: rtl/rx_idle_run_counter.sv
module rx_idle_run_counter #(
  parameter int unsigned IDLE_RUN = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic enable,
  input  logic sym_idle,
  output logic run_done,
  output logic cnt_zero
);
  import rx_jabber_pkg::*;

  localparam int unsigned CW = $clog2(IDLE_RUN + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clear) begin
      run_q <= '0;
    end else if (enable) begin
      if (!sym_idle) begin
        run_q <= '0;
      end else if (run_q != CW'(IDLE_RUN)) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign run_done = enable && idle_run_closes(32'(run_q), sym_idle, IDLE_RUN);
  assign cnt_zero = (run_q == '0);

endmodule

// File: rtl/rx_duration_timer.sv
module rx_duration_timer #(
  parameter int unsigned TIMEOUT = 18050
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic at_limit
);
  import rx_jabber_pkg::*;

  localparam int unsigned TW = $clog2(TIMEOUT + 1);

  logic [TW-1:0] elapsed_q;
  logic          last_slot;

  assign last_slot = duration_at_limit(32'(elapsed_q), TIMEOUT);
  assign at_limit  = run && last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
    end else if (clear) begin
      elapsed_q <= '0;
    end else if (run && !last_slot) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

endmodule

// File: rtl/rx_monitor_fsm.sv
module rx_monitor_fsm (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_active,
  input  logic                      sym_idle,
  input  logic                      run_done,
  input  logic                      at_limit,
  output rx_jabber_pkg::mon_state_e state,
  output logic                      start,
  output logic                      end_pulse
);
  import rx_jabber_pkg::*;

  mon_state_e state_q, state_d;
  logic       end_d;

  assign start = (state_q == MON_IDLE) && rx_active;

  always_comb begin
    state_d = state_q;
    end_d   = 1'b0;
    unique case (state_q)
      MON_IDLE: begin
        if (rx_active) state_d = MON_RECV;
      end
      MON_RECV: begin
        if (run_done) begin
          state_d = MON_IDLE;
          end_d   = 1'b1;
        end else if (at_limit) begin
          state_d = sym_idle ? MON_GRACE : MON_JAB;
        end
      end
      MON_GRACE: begin
        if (run_done) begin
          state_d = MON_IDLE;
          end_d   = 1'b1;
        end else if (!sym_idle) begin
          state_d = MON_JAB;
        end
      end
      MON_JAB: begin
        if (run_done) begin
          state_d = MON_IDLE;
          end_d   = 1'b1;
        end
      end
      default: state_d = MON_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= MON_IDLE;
      end_pulse <= 1'b0;
    end else begin
      state_q   <= state_d;
      end_pulse <= end_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/rx_jabber_monitor.sv
module rx_jabber_monitor #(
  parameter int unsigned TIMEOUT  = 18050,
  parameter int unsigned IDLE_RUN = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_active,
  input  logic sym_idle,
  output logic crs,
  output logic jabber,
  output logic rx_end
);
  import rx_jabber_pkg::*;

  mon_state_e state;
  logic       start;
  logic       in_rx;
  logic       counting;
  logic       run_done;
  logic       idle_cnt_zero;
  logic       expire;

  assign in_rx    = (state != MON_IDLE);
  assign counting = (state == MON_RECV);

  rx_idle_run_counter #(.IDLE_RUN(IDLE_RUN)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .enable   (in_rx),
    .sym_idle (sym_idle),
    .run_done (run_done),
    .cnt_zero (idle_cnt_zero)
  );

  rx_duration_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .run      (counting),
    .at_limit (expire)
  );

  rx_monitor_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_active (rx_active),
    .sym_idle  (sym_idle),
    .run_done  (run_done),
    .at_limit  (expire),
    .state     (state),
    .start     (start),
    .end_pulse (rx_end)
  );

  assign crs    = in_rx;
  assign jabber = (state == MON_JAB);

endmodule

// File: rtl/rx_jabber_monitor_checker.sv
module rx_jabber_monitor_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_active,
  input logic sym_idle,
  input logic crs,
  input logic jabber,
  input logic rx_end,
  input logic run_done,
  input logic expire,
  input logic idle_cnt_zero
);

  AST_START_RAISES_CRS: assert property (@(posedge clk) disable iff (!rst_n)
    (!crs && rx_active) |=> crs); // R2

  AST_END_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |=> !rx_end); // R3

  AST_END_DROPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |-> (!crs && !jabber)); // R3

  AST_NONIDLE_RESTARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (crs && !sym_idle) |=> idle_cnt_zero); // R4

  AST_END_BEATS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_done && expire) |=> (rx_end && !jabber)); // R6

  AST_JAB_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jabber) |-> $past(!sym_idle)); // R7

  AST_JAB_WITH_CRS: assert property (@(posedge clk) disable iff (!rst_n)
    jabber |-> crs); // R8

  AST_JAB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    jabber |=> (jabber || rx_end)); // R9

  AST_ACTIVE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (crs && rx_active && !run_done) |=> (crs && !rx_end)); // R10

endmodule

bind rx_jabber_monitor rx_jabber_monitor_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_active     (rx_active),
  .sym_idle      (sym_idle),
  .crs           (crs),
  .jabber        (jabber),
  .rx_end        (rx_end),
  .run_done      (run_done),
  .expire        (expire),
  .idle_cnt_zero (idle_cnt_zero)
);

// File: tb/rx_jabber_monitor_bench.sv
module rx_jabber_monitor_bench;

  localparam int unsigned LIM = 40;
  localparam int unsigned RUN = 6;
  localparam int NVEC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_active = 1'b0;
  logic sym_idle = 1'b1;
  logic crs, jabber, rx_end;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rx_jabber_monitor #(.TIMEOUT(LIM), .IDLE_RUN(RUN)) u_rx_jabber_monitor (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_active (rx_active),
    .sym_idle  (sym_idle),
    .crs       (crs),
    .jabber    (jabber),
    .rx_end    (rx_end)
  );

  // {data symbols, burst start, burst length, hold rx_active}
  localparam logic [24:0] VECS [NVEC] = '{
    {8'd5,  8'd0,  8'd0, 1'b0},
    {8'd20, 8'd8,  8'd5, 1'b0},
    {8'd34, 8'd0,  8'd0, 1'b0},
    {8'd35, 8'd0,  8'd0, 1'b0},
    {8'd39, 8'd0,  8'd0, 1'b0},
    {8'd40, 8'd0,  8'd0, 1'b0},
    {8'd60, 8'd0,  8'd0, 1'b0},
    {8'd45, 8'd38, 8'd3, 1'b0},
    {8'd38, 8'd0,  8'd0, 1'b0},
    {8'd38, 8'd0,  8'd0, 1'b0},
    {8'd40, 8'd0,  8'd0, 1'b1},
    {8'd1,  8'd0,  8'd0, 1'b1}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0:       return "R3 short packet";
      1:       return "R4 idle burst inside data";
      2:       return "R6 run ends on limit";
      3:       return "R7 run pending at limit";
      4:       return "R5 R7 one idle at limit";
      5:       return "R8 R9 data on limit";
      6:       return "R8 R9 long jabber";
      7:       return "R7 burst across limit";
      8, 9:    return "R11 back-to-back";
      default: return "R10 rx_active held";
    endcase
  endfunction

  function automatic logic line_idle(input int s, input int d, input int p, input int b);
    return (s > d) || (b != 0 && s >= p && s < p + b);
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {crs,jabber,rx_end} = %b, expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_packet(input int d, input int p, input int b, input bit hold,
                            input string tag);
    int last_sym;
    int jab_from;
    logic [2:0] exp;
    last_sym = d + int'(RUN);
    jab_from = 0;
    for (int s = int'(LIM); s <= d; s++)
      if (jab_from == 0 && !line_idle(s, d, p, b)) jab_from = s;
    @(negedge clk);
    rx_active = 1'b1;
    sym_idle  = 1'b1;
    @(posedge clk); #1;
    check({tag, " start"}, {crs, jabber, rx_end}, 3'b100);
    for (int s = 1; s <= last_sym; s++) begin
      @(negedge clk);
      rx_active = hold;
      sym_idle  = line_idle(s, d, p, b);
      @(posedge clk); #1;
      if (s == last_sym) exp = 3'b001;
      else exp = {1'b1, (jab_from != 0 && s >= jab_from), 1'b0};
      check(tag, {crs, jabber, rx_end}, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset", {crs, jabber, rx_end}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", {crs, jabber, rx_end}, 3'b000);

    // R2: traffic without rx_active never opens a reception
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rx_active = 1'b0;
      sym_idle  = i[0];
      @(posedge clk); #1;
      check("R2 no start without rx_active", {crs, jabber, rx_end}, 3'b000);
    end

    for (int v = 0; v < NVEC; v++) begin
      run_packet(int'(VECS[v][24:17]), int'(VECS[v][16:9]), int'(VECS[v][8:1]),
                 VECS[v][0], vec_tag(v));
    end
    @(negedge clk);
    rx_active = 1'b0;
    sym_idle  = 1'b1;

    // R1: reset while jabber is active
    @(negedge clk);
    rx_active = 1'b1;
    @(negedge clk);
    rx_active = 1'b0;
    for (int s = 1; s <= int'(LIM) + 2; s++) begin
      sym_idle = 1'b0;
      @(negedge clk);
    end
    check("R8 jabber before reset", {crs, jabber, rx_end}, 3'b110);
    rst_n = 1'b0;
    #1;
    check("R1 reset mid-jabber", {crs, jabber, rx_end}, 3'b000);
    @(negedge clk);
    sym_idle = 1'b1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 quiet after mid-jabber reset", {crs, jabber, rx_end}, 3'b000);

    // R11: fresh count after reset and after a jabber reception
    run_packet(39, 0, 0, 1'b0, "R11 R5 after reset");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule